// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block runs erase and program jobs on one bank of an 8-bit parallel NOR flash. It drives the flash through a registered address bus, a data-out byte, a data-in byte and two active-low strobes: one for writes and one for reads. An erase request issues the sector-erase command train. A program request walks the bank one byte at a time and issues a program command train for each byte, taking the data from a byte source that the block addresses itself.

After each embedded operation the block polls the bank base. The flash is treated as finished once two back-to-back reads return the same byte, and an attempt counter limits how long it waits. When the job completes, the block writes the read-mode command and reads the whole bank back. An erase is verified against the erased value. A program is verified against the source bytes.

The controller sees a busy level while a job runs. At the end it sees a one-cycle done pulse, together with two sticky error flags: timeout and verify failure. Strobe width, settle time, read width and the polling limit are parameters.

Top module: `nor_cmd_seq`

## Requirements
- R1: An erase job issues exactly six writes, given as (offset, data): (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x000,0x30).
- R2: A program job issues, for byte offsets 0 up to BANK_BYTES-1 in rising order, four writes each: (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), then (offset, src_data). src_data is the value the source returns while src_addr equals that offset.
- R3: After each command train the block reads offset 0 in pairs. It stops at the first pair whose two bytes are equal and starts no other bus cycle until then.
- R4: If POLL_MAX pairs in a row differ, err_timeout is set and the job ends. The read-mode write and the read-back are skipped, and in a program job the remaining bytes are dropped.
- R5: After a successful poll that ends an erase, or after the last byte of a program, one write of 0xF0 to offset 0 is issued before any read-back.
- R6: An erase read-back reads offsets 0 upward and expects 0xFF. It stops at the first differing byte and sets err_verify.
- R7: A program read-back reads offsets 0 upward and compares each byte with src_data for that offset. It stops at the first mismatch and sets err_verify.
- R8: Each write holds fl_we_n low for exactly WE_HOLD cycles and each read holds fl_oe_n low for exactly RD_HOLD cycles. Address and data stay stable during the strobe. The two strobes are never low together. Between two writes fl_we_n stays high for at least SETTLE+1 cycles.
- R9: A start is taken only while busy is low, and start_erase wins when both starts are high. busy is high from the cycle after the start until done. done is a one-cycle pulse with busy low. Both error flags keep their value until the next accepted start.
- R10: Out of reset both strobes are high, and busy, done, err_timeout and err_verify are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_erase | input | 1 | Request an erase job |
| start_prog | input | 1 | Request a program job |
| src_addr | output | $clog2(BANK_BYTES) | Byte offset presented to the data source |
| src_data | input | 8 | Source byte for src_addr |
| fl_addr | output | ADDR_W | Flash byte offset |
| fl_dout | output | 8 | Byte driven to the flash on writes |
| fl_din | input | 8 | Byte returned by the flash on reads |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read strobe, active low |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| err_timeout | output | 1 | Completion poll gave up |
| err_verify | output | 1 | Read-back mismatch |

## Verification
The hardest situation to reach from the ports is a poll that runs out exactly at POLL_MAX in the middle of a program job, with earlier bytes already finished normally. The bench's flash model toggles its status on every read during a programmable busy window. The model can hold that window open forever for one chosen target offset, so the timeout falls on byte 2 after bytes 0 and 1 have completed. Odd and even busy lengths are swept so that a finish lands between the two reads of a pair as well as on a pair boundary. Stuck erase bits and corrupted program bytes are injected to drive the early stop of the read-back.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {OP_NONE, OP_ERASE, OP_PROG} op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_POLL1, S_POLL2, S_RST, S_VFY, S_END
  } seq_st_e;

  typedef struct packed {
    logic [10:0] off;
    logic [7:0]  data;
  } cmd_t;

  localparam int ERASE_STEPS = 6;
  localparam int PROG_STEPS  = 4;

  localparam logic [10:0] OFF_KEY1  = 11'h555;
  localparam logic [10:0] OFF_KEY2  = 11'h2AA;
  localparam logic [7:0]  KEY1      = 8'hAA;
  localparam logic [7:0]  KEY2      = 8'h55;
  localparam logic [7:0]  ERASE_PRE = 8'h80;
  localparam logic [7:0]  ERASE_GO  = 8'h30;
  localparam logic [7:0]  PROG_GO   = 8'hA0;
  localparam logic [7:0]  READ_MODE = 8'hF0;
  localparam logic [7:0]  BLANK     = 8'hFF;

  // Unlock pair: step 0 and 1 of every command train
  function automatic cmd_t key_step(input logic k);
    cmd_t c;
    if (!k) c = '{off: OFF_KEY1, data: KEY1};
    else    c = '{off: OFF_KEY2, data: KEY2};
    return c;
  endfunction

  function automatic cmd_t erase_step(input logic [2:0] k);
    cmd_t c;
    case (k)
      3'd0, 3'd3: c = key_step(1'b0);
      3'd1, 3'd4: c = key_step(1'b1);
      3'd2:       c = '{off: OFF_KEY1, data: ERASE_PRE};
      default:    c = '{off: 11'h000, data: ERASE_GO};
    endcase
    return c;
  endfunction

  // Steps 0..2 of a byte program; step 3 carries the target byte
  function automatic cmd_t prog_step(input logic [2:0] k);
    cmd_t c;
    case (k)
      3'd0:    c = key_step(1'b0);
      3'd1:    c = key_step(1'b1);
      default: c = '{off: OFF_KEY1, data: PROG_GO};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int ADDR_W  = 11,
  parameter int WE_HOLD = 2,
  parameter int RD_HOLD = 2,
  parameter int SETTLE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              ack,
  output logic [7:0]        rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dout,
  input  logic [7:0]        fl_din,
  output logic              fl_we_n,
  output logic              fl_oe_n
);

  localparam int STRB_MAX = (WE_HOLD > RD_HOLD) ? WE_HOLD : RD_HOLD;
  localparam int MAXC     = (STRB_MAX > SETTLE) ? STRB_MAX : SETTLE;
  localparam int CW       = $clog2(MAXC + 1);

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STRB, B_RECOV} bst_e;

  bst_e          bst;
  logic [CW-1:0] cnt;
  logic          wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bst     <= B_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      ack     <= 1'b0;
      rdata   <= '0;
      fl_addr <= '0;
      fl_dout <= '0;
      fl_we_n <= 1'b1;
      fl_oe_n <= 1'b1;
    end else begin
      ack <= 1'b0;
      case (bst)
        B_IDLE: begin
          if (req) begin
            fl_addr <= addr;
            fl_dout <= wdata;
            wr_q    <= is_wr;
            bst     <= B_SETUP;
          end
        end
        B_SETUP: begin
          if (wr_q) begin
            fl_we_n <= 1'b0;
            cnt     <= CW'(WE_HOLD - 1);
          end else begin
            fl_oe_n <= 1'b0;
            cnt     <= CW'(RD_HOLD - 1);
          end
          bst <= B_STRB;
        end
        B_STRB: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b1;
            fl_oe_n <= 1'b1;
            if (!wr_q) rdata <= fl_din;
            cnt <= wr_q ? CW'(SETTLE - 1) : '0;
            bst <= B_RECOV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            ack <= 1'b1;
            bst <= B_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // Strobe-run observers used only by the checks below
  logic [15:0] we_lo_run, oe_lo_run, we_hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_run <= '0;
      oe_lo_run <= '0;
      we_hi_run <= '1;
    end else begin
      we_lo_run <= fl_we_n ? '0 : we_lo_run + 1'b1;
      oe_lo_run <= fl_oe_n ? '0 : oe_lo_run + 1'b1;
      if (!fl_we_n)             we_hi_run <= '0;
      else if (we_hi_run != '1) we_hi_run <= we_hi_run + 1'b1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n)); // R8
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> (we_lo_run == 16'(WE_HOLD))); // R8
  AST_OE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_oe_n) |-> (oe_lo_run == 16'(RD_HOLD))); // R8
  AST_WR_SETTLE: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we_n) |-> (we_hi_run >= 16'(SETTLE + 1))); // R8
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout))); // R8
  AST_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    req |-> (bst == B_IDLE)); // R3

endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int POLL_MAX = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic last
);

  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(POLL_MAX - 1));

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(POLL_MAX)); // R4
  AST_NO_TICK_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    tick |-> !last); // R4

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int BANK_BYTES = 16,
  parameter int POLL_MAX   = 1000000,
  parameter int WE_HOLD    = 2,
  parameter int RD_HOLD    = 2,
  parameter int SETTLE     = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_erase,
  input  logic                          start_prog,
  output logic [$clog2(BANK_BYTES)-1:0] src_addr,
  input  logic [7:0]                    src_data,
  output logic [ADDR_W-1:0]             fl_addr,
  output logic [7:0]                    fl_dout,
  input  logic [7:0]                    fl_din,
  output logic                          fl_we_n,
  output logic                          fl_oe_n,
  output logic                          busy,
  output logic                          done,
  output logic                          err_timeout,
  output logic                          err_verify
);

  localparam int              IW       = $clog2(BANK_BYTES);
  localparam logic [IW-1:0]   LAST_IDX = IW'(BANK_BYTES - 1);

  seq_st_e       st;
  op_e           op;
  logic [2:0]    step;
  logic [IW-1:0] idx;
  logic          wait_ack;
  logic [7:0]    first_rd;

  logic              bus_req, bus_wr, bus_ack;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata, bus_rdata;
  logic              poll_clr, poll_tick, poll_last;
  logic              acc, pair_eq;
  logic [2:0]        last_step;
  logic [7:0]        vfy_exp;
  cmd_t              cmd_c;

  assign src_addr  = idx;
  assign acc       = (st == S_CMD) || (st == S_POLL1) || (st == S_POLL2) ||
                     (st == S_RST) || (st == S_VFY);
  assign bus_req   = acc && !wait_ack;
  assign bus_wr    = (st == S_CMD) || (st == S_RST);
  assign last_step = (op == OP_ERASE) ? 3'(ERASE_STEPS - 1) : 3'(PROG_STEPS - 1);
  assign pair_eq   = (bus_rdata == first_rd);
  assign vfy_exp   = (op == OP_ERASE) ? BLANK : src_data;
  assign poll_clr  = (st != S_POLL1) && (st != S_POLL2);
  assign poll_tick = (st == S_POLL2) && bus_ack && !pair_eq && !poll_last;

  always_comb begin
    cmd_c     = (op == OP_ERASE) ? erase_step(step) : prog_step(step);
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_CMD: begin
        if (op == OP_PROG && step == 3'(PROG_STEPS - 1)) begin
          bus_addr  = ADDR_W'(idx);
          bus_wdata = src_data;
        end else begin
          bus_addr  = ADDR_W'(cmd_c.off);
          bus_wdata = cmd_c.data;
        end
      end
      S_RST:   bus_wdata = READ_MODE;
      S_VFY:   bus_addr  = ADDR_W'(idx);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      op          <= OP_NONE;
      step        <= '0;
      idx         <= '0;
      wait_ack    <= 1'b0;
      first_rd    <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_verify  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (bus_req)      wait_ack <= 1'b1;
      else if (bus_ack) wait_ack <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_erase || start_prog) begin
            op          <= start_erase ? OP_ERASE : OP_PROG;
            busy        <= 1'b1;
            err_timeout <= 1'b0;
            err_verify  <= 1'b0;
            step        <= '0;
            idx         <= '0;
            st          <= S_CMD;
          end
        end
        S_CMD: begin
          if (bus_ack) begin
            if (step == last_step) begin
              step <= '0;
              st   <= S_POLL1;
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        S_POLL1: begin
          if (bus_ack) begin
            first_rd <= bus_rdata;
            st       <= S_POLL2;
          end
        end
        S_POLL2: begin
          if (bus_ack) begin
            if (pair_eq) begin
              if (op == OP_PROG && idx != LAST_IDX) begin
                idx <= idx + 1'b1;
                st  <= S_CMD;
              end else begin
                idx <= '0;
                st  <= S_RST;
              end
            end else if (poll_last) begin
              err_timeout <= 1'b1;
              st          <= S_END;
            end else begin
              st <= S_POLL1;
            end
          end
        end
        S_RST: begin
          if (bus_ack) st <= S_VFY;
        end
        S_VFY: begin
          if (bus_ack) begin
            if (bus_rdata != vfy_exp) begin
              err_verify <= 1'b1;
              st         <= S_END;
            end else if (idx == LAST_IDX) begin
              st <= S_END;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  nor_bus_cycle #(
    .ADDR_W (ADDR_W),
    .WE_HOLD(WE_HOLD),
    .RD_HOLD(RD_HOLD),
    .SETTLE (SETTLE)
  ) i_bus (
    .clk    (clk),
    .rst    (rst),
    .req    (bus_req),
    .is_wr  (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .ack    (bus_ack),
    .rdata  (bus_rdata),
    .fl_addr(fl_addr),
    .fl_dout(fl_dout),
    .fl_din (fl_din),
    .fl_we_n(fl_we_n),
    .fl_oe_n(fl_oe_n)
  );

  nor_poll_timer #(
    .POLL_MAX(POLL_MAX)
  ) i_poll (
    .clk (clk),
    .rst (rst),
    .clr (poll_clr),
    .tick(poll_tick),
    .last(poll_last)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R9
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (rst)
    !(err_timeout && err_verify)); // R4
  AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (rst)
    $rose(err_timeout) |-> (st == S_END)); // R4
  AST_READBACK_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (st == S_VFY) |-> fl_we_n); // R6

endmodule

// File: tb/test_nor_cmd_seq.sv
module test_nor_cmd_seq;

  localparam int ADDR_W   = 11;
  localparam int BANK     = 16;
  localparam int POLL_MAX = 40;
  localparam int WE_HOLD  = 3;
  localparam int RD_HOLD  = 2;
  localparam int SETTLE   = 2;
  localparam int IW       = $clog2(BANK);
  localparam int LIMIT    = 20000;
  localparam int BIG      = 1 << 30;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_erase = 1'b0, start_prog = 1'b0;
  logic [IW-1:0]     src_addr;
  logic [7:0]        src_data;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0]        fl_dout, fl_din;
  logic              fl_we_n, fl_oe_n, busy, done, err_timeout, err_verify;

  always #10 clk = ~clk;

  int nvec = 0, nfail = 0;
  int seed = 5;

  assign src_data = 8'((int'(src_addr) * 37 + seed) & 255);

  nor_cmd_seq #(
    .ADDR_W(ADDR_W), .BANK_BYTES(BANK), .POLL_MAX(POLL_MAX),
    .WE_HOLD(WE_HOLD), .RD_HOLD(RD_HOLD), .SETTLE(SETTLE)
  ) i_nor_cmd_seq (
    .clk(clk), .rst(rst), .start_erase(start_erase), .start_prog(start_prog),
    .src_addr(src_addr), .src_data(src_data), .fl_addr(fl_addr),
    .fl_dout(fl_dout), .fl_din(fl_din), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .busy(busy), .done(done), .err_timeout(err_timeout), .err_verify(err_verify)
  );

  // ---------------- flash model ----------------
  logic [7:0] mem [BANK];
  int busy_len = 0, busy_left = 0, tog = 0;
  bit stuck_erase = 0;
  int stuck_prog = -1, erase_fault = -1, prog_fault = -1;
  int rd_cnt = 0, bad_w = 0, bad_r = 0, clash = 0, min_gap = 1000;
  int we_lo = 0, we_hi = 1000, oe_lo = 0;
  int log_n = 0;
  int log_a [256];
  int log_d [256];
  int ha [6];
  int hd [6];

  function automatic int srcv(input int a);
    return (a * 37 + seed) & 255;
  endfunction

  function automatic int pollr(input int b);
    return b + 2 + (b & 1);
  endfunction

  assign fl_din = (busy_left > 0) ? ((tog != 0) ? 8'h83 : 8'hC3)
                : ((int'(fl_addr) < BANK) ? mem[int'(fl_addr)] : 8'h00);

  task automatic hist_clear();
    for (int k = 0; k < 6; k++) begin ha[k] = -1; hd[k] = -1; end
  endtask

  task automatic do_write(input int a, input int d);
    if (log_n < 256) begin log_a[log_n] = a; log_d[log_n] = d; end
    log_n++;
    for (int k = 0; k < 5; k++) begin ha[k] = ha[k+1]; hd[k] = hd[k+1]; end
    ha[5] = a; hd[5] = d;
    if (ha[2] == 'h555 && hd[2] == 'hAA && ha[3] == 'h2AA && hd[3] == 'h55 &&
        ha[4] == 'h555 && hd[4] == 'hA0) begin
      if (a < BANK) mem[a] = 8'(d ^ ((a == prog_fault) ? 'h10 : 0));
      busy_left = (a == stuck_prog) ? BIG : busy_len;
      hist_clear();
    end else if (ha[0] == 'h555 && hd[0] == 'hAA && ha[1] == 'h2AA && hd[1] == 'h55 &&
                 ha[2] == 'h555 && hd[2] == 'h80 && ha[3] == 'h555 && hd[3] == 'hAA &&
                 ha[4] == 'h2AA && hd[4] == 'h55 && ha[5] == 0 && hd[5] == 'h30) begin
      for (int i = 0; i < BANK; i++) mem[i] = (i == erase_fault) ? 8'h00 : 8'hFF;
      busy_left = stuck_erase ? BIG : busy_len;
      hist_clear();
    end else if (a == 0 && d == 'hF0) begin
      busy_left = 0;
      hist_clear();
    end
  endtask

  always @(posedge clk) begin
    if (!fl_we_n && !fl_oe_n) clash++;
    if (!fl_we_n) begin
      if (we_hi > 0 && we_hi < min_gap) min_gap = we_hi;
      we_hi = 0;
      we_lo++;
    end else begin
      if (we_lo != 0) begin
        if (we_lo != WE_HOLD) bad_w++;
        do_write(int'(fl_addr), int'(fl_dout));
        we_lo = 0;
      end
      if (we_hi < 1000) we_hi++;
    end
    if (!fl_oe_n) oe_lo++;
    else if (oe_lo != 0) begin
      if (oe_lo != RD_HOLD) bad_r++;
      rd_cnt++;
      if (busy_left > 0) begin tog ^= 1; busy_left--; end
      oe_lo = 0;
    end
  end

  task automatic model_setup(input int b, input bit se, input int sp, input int ef, input int pf);
    busy_len = b; stuck_erase = se; stuck_prog = sp; erase_fault = ef; prog_fault = pf;
    busy_left = 0; tog = 0; rd_cnt = 0; bad_w = 0; bad_r = 0; clash = 0;
    min_gap = 1000; log_n = 0;
    hist_clear();
  endtask

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input bit er, input bit pr, input int inject);
    int cyc;
    @(negedge clk);
    start_erase = er; start_prog = pr;
    @(negedge clk);
    start_erase = 1'b0; start_prog = 1'b0;
    chk("R9", "busy after start", busy, 1);
    cyc = 0;
    while (done !== 1'b1 && cyc < LIMIT) begin
      start_prog = (cyc == inject);
      @(negedge clk);
      cyc++;
    end
    start_prog = 1'b0;
    if (cyc >= LIMIT) chk("R9", "watchdog expired, no done", 0, 1);
    else chk("R9", "busy low with done", busy, 0);
  endtask

  task automatic check_after_done();
    @(negedge clk);
    chk("R9", "done is one cycle", done, 0);
  endtask

  task automatic check_log(input string tag, input bit is_prog, input int nbytes, input bit with_rst);
    int exp_n, mism, ea, ed, j, s;
    exp_n = (is_prog ? 4 * nbytes : 6) + (with_rst ? 1 : 0);
    chk(tag, "write count", log_n, exp_n);
    mism = 0;
    for (j = 0; j < exp_n && j < log_n; j++) begin
      if (with_rst && j == exp_n - 1) begin ea = 0; ed = 'hF0; end
      else if (!is_prog) begin
        case (j)
          0, 3:    begin ea = 'h555; ed = 'hAA; end
          1, 4:    begin ea = 'h2AA; ed = 'h55; end
          2:       begin ea = 'h555; ed = 'h80; end
          default: begin ea = 0;     ed = 'h30; end
        endcase
      end else begin
        s = j % 4;
        case (s)
          0:       begin ea = 'h555; ed = 'hAA; end
          1:       begin ea = 'h2AA; ed = 'h55; end
          2:       begin ea = 'h555; ed = 'hA0; end
          default: begin ea = j / 4; ed = srcv(j / 4); end
        endcase
      end
      if (log_a[j] != ea || log_d[j] != ed) mism++;
    end
    chk(tag, "write sequence mismatches", mism, 0);
  endtask

  task automatic check_timing();
    chk("R8", "write strobe width errors", bad_w, 0);
    chk("R8", "read strobe width errors", bad_r, 0);
    chk("R8", "overlapping strobes", clash, 0);
    chk("R8", "write gap >= SETTLE+1", (min_gap >= SETTLE + 1) ? 1 : 0, 1);
  endtask

  int blens [5] = '{0, 1, 2, 3, 6};

  initial begin
    int nbad;
    for (int i = 0; i < BANK; i++) mem[i] = 8'h00;
    hist_clear();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "we_n in reset", fl_we_n, 1);
    chk("R10", "oe_n in reset", fl_oe_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "busy after reset", busy, 0);
    chk("R10", "done after reset", done, 0);
    chk("R10", "flags after reset", {err_timeout, err_verify}, 0);

    // Sweep busy lengths and seeds over erase then program
    for (int bi = 0; bi < 5; bi++) begin
      seed = (bi % 2 == 0) ? 5 : 90;
      model_setup(blens[bi], 0, -1, -1, -1);
      run_op(1, 0, -1);
      chk("R6", "erase flags", {err_timeout, err_verify}, 0);
      check_after_done();
      check_log("R1", 0, 0, 1);
      check_log("R5", 0, 0, 1);
      nbad = 0;
      for (int i = 0; i < BANK; i++) if (mem[i] != 8'hFF) nbad++;
      chk("R6", "bytes not erased", nbad, 0);
      chk("R3", "erase read count", rd_cnt, pollr(blens[bi]) + BANK);
      check_timing();

      model_setup(blens[bi], 0, -1, -1, -1);
      run_op(0, 1, -1);
      chk("R7", "program flags", {err_timeout, err_verify}, 0);
      check_after_done();
      check_log("R2", 1, BANK, 1);
      nbad = 0;
      for (int i = 0; i < BANK; i++) if (int'(mem[i]) != srcv(i)) nbad++;
      chk("R7", "bytes differing from source", nbad, 0);
      chk("R3", "program read count", rd_cnt, BANK * pollr(blens[bi]) + BANK);
      check_timing();
    end

    // R6: stuck byte after erase stops read-back at offset 7
    model_setup(2, 0, -1, 7, -1);
    run_op(1, 0, -1);
    chk("R6", "erase verify flag", err_verify, 1);
    chk("R6", "erase timeout flag", err_timeout, 0);
    chk("R6", "reads up to failing byte", rd_cnt, pollr(2) + 8);
    repeat (4) @(negedge clk);
    chk("R9", "verify flag held", err_verify, 1);

    // R7: corrupted program byte 5
    seed = 5;
    model_setup(1, 0, -1, -1, 5);
    run_op(0, 1, -1);
    chk("R7", "program verify flag", err_verify, 1);
    chk("R7", "reads up to failing byte", rd_cnt, BANK * pollr(1) + 6);

    // R4: erase never finishes
    model_setup(0, 1, -1, -1, -1);
    run_op(1, 0, -1);
    chk("R4", "erase timeout flag", err_timeout, 1);
    chk("R4", "erase verify flag", err_verify, 0);
    chk("R4", "poll reads at limit", rd_cnt, 2 * POLL_MAX);
    check_log("R4", 0, 0, 0);

    // R4: program stuck on byte 2, later bytes dropped
    model_setup(2, 0, 2, -1, -1);
    run_op(0, 1, -1);
    chk("R4", "program timeout flag", err_timeout, 1);
    chk("R4", "reads with timeout", rd_cnt, 2 * pollr(2) + 2 * POLL_MAX);
    check_log("R4", 1, 3, 0);
    repeat (4) @(negedge clk);
    chk("R9", "timeout flag held", err_timeout, 1);

    // R9: both starts -> erase; start during busy ignored
    model_setup(1, 0, -1, -1, -1);
    run_op(1, 1, 30);
    chk("R9", "flags cleared by new start", {err_timeout, err_verify}, 0);
    check_log("R9", 0, 0, 1);
    repeat (3) @(negedge clk);
    chk("R9", "no queued job", busy, 0);
    chk("R9", "no extra writes", log_n, 7);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule